// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Pin-Change Interrupts

This block is one eight-pin general-purpose I/O port. Software reaches it through a small word-wide register bus. Writes are committed on the clock edge. Reads are combinational from the current register state. Each pin can be in one of two modes:

- **GPIO mode:** the pin is driven from a data-out register and an output-enable (direction) register.
- **Alternate mode:** the pin is handed to a peripheral, which supplies the pin's value and enable.

A weak-pull control is exported per pin. The polarity of the pull follows the data-out bit.

Pin inputs are brought into the clock domain by a two-stage synchroniser. A per-pin polarity register picks the pin transition that sets the pin's change flag. The flag is set whenever the term (polarity XOR synchronised pin) goes from 0 to 1.

Flags are kept until software clears them. A level interrupt request is raised while any flag has its enable bit set. A vector register returns a branch-table offset for the lowest pending enabled pin. Reading the vector register retires that pin's flag.

The block holds no state machine. Its state consists of:

- the six control registers,
- the synchroniser chain,
- the previous-sense register,
- the flag register.

Each of these loads on every clock edge from bus writes or pin activity.

Top module: `gpio_port`

Register addresses on `bus_addr_i` (data in bits 7:0 of the bus, upper bits read 0 except in the vector register):

| Address | Register |
|---|---|
| 0 | synchronised pins, read only |
| 1 | data out |
| 2 | direction |
| 3 | alternate select |
| 4 | pull enable |
| 5 | polarity |
| 6 | interrupt enable |
| 7 | flags |
| 8 | vector |

## Requirements
- R1: After reset, all control registers and flags (addresses 1 to 7) read 0. `pin_oe_o`, `pull_en_o` and `irq_o` are 0, and the vector (address 8) reads 0.
- R2: Address 0 returns the pin inputs through a two-flop synchroniser. A pin value driven before clock edge k reads back after edge k+2 and not after edge k+1.
- R3: For a pin whose select bit (address 3) is 0, `pin_oe_o` equals its direction bit (address 2, 1 = output) and `pin_o` equals its data-out bit (address 1).
- R4: For a pin whose select bit is 1, `pin_o` and `pin_oe_o` follow `alt_out_i` and `alt_oe_i`, and the GPIO registers have no effect on that pin.
- R5: `pull_en_o` equals the pull-enable register (address 4), regardless of direction. `pull_up_o` equals the data-out register (1 = pull up, 0 = pull down).
- R6: A flag bit (address 7) sets when polarity-bit XOR synchronised-pin goes from 0 to 1. With polarity 0 this is a rising pin; with polarity 1 it is a falling pin. The flag is visible after the third clock edge following the pin change. The opposite transition sets nothing.
- R7: `irq_o` is 1 exactly when some pin has both its flag bit and its enable bit (address 6) set.
- R8: A bus write to address 7 loads the flags, so software can both set and clear them. A hardware set on a bit in the same cycle as such a write wins, and that bit ends up set.
- R9: The vector register (address 8) reads 2n+2, where n is the lowest pin that is flagged and enabled. It reads 0 when no such pin exists.
- R10: A bus read of address 8 clears only the flag bit it reported, at the edge ending the read. Other flags are untouched, and a read returning 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_sel_i | input | 1 | bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | register address |
| bus_wdata_i | input | 16 | write data |
| bus_rdata_o | output | 16 | read data, combinational |
| pin_i | input | 8 | pad input values |
| alt_out_i | input | 8 | peripheral output values |
| alt_oe_i | input | 8 | peripheral output enables |
| pin_o | output | 8 | pad output values |
| pin_oe_o | output | 8 | pad output enables |
| pull_en_o | output | 8 | weak pull enable |
| pull_up_o | output | 8 | pull direction, 1 = up |
| irq_o | output | 1 | interrupt request |

## Verification
Results fall due at four different times:

- **Pad controls** follow a register write immediately after the committing edge.
- **Read data** is valid within the cycle of the access.
- **The input register** reflects a pin change two edges after it.
- **A change flag and the interrupt request** appear three edges after it.

Stimulus is applied on the falling clock edge and outputs are sampled just after. The bench counts rising edges explicitly between a pin change and each check. It samples one edge early as well as on time, so that an early result is caught as well as a late one. The same-cycle contention case is timed so that the bus write commits on exactly the edge where the hardware set lands.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_PINS  = 4'd0,
        REG_DOUT  = 4'd1,
        REG_DIR   = 4'd2,
        REG_ASEL  = 4'd3,
        REG_PULL  = 4'd4,
        REG_POL   = 4'd5,
        REG_IEN   = 4'd6,
        REG_FLAG  = 4'd7,
        REG_VEC   = 4'd8
    } reg_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[s] <= '0;
                    else         chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[s] <= '0;
                    else         chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sense_i,
    input  logic         sw_we_i,
    input  logic [W-1:0] sw_data_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] set_o,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] sense_q;
    logic [W-1:0] flag_d;

    assign set_o = sense_i & ~sense_q;

    always_comb begin
        flag_d = sw_we_i ? sw_data_i : flag_o;
        flag_d = flag_d & ~clr_mask_i;
        flag_d = flag_d | set_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sense_q <= '0;
            flag_o  <= '0;
        end else begin
            sense_q <= sense_i;
            flag_o  <= flag_d;
        end
    end

    // R8: a hardware set always lands, whatever the bus did in that cycle
    a_r8_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_o) |=> ((flag_o & $past(set_o)) == $past(set_o)));

    // R6: with no bus write and no clear, flags never drop
    a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sw_we_i && clr_mask_i == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/gpio_prio_vec.sv
module gpio_prio_vec #(
    parameter int W  = 8,
    parameter int DW = 16
) (
    input  logic [W-1:0]  pend_i,
    output logic [W-1:0]  hit_o,
    output logic [DW-1:0] vec_o
);
    always_comb begin
        hit_o = '0;
        vec_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit_o = '0;
                hit_o[i] = 1'b1;
                vec_o = DW'(2 * i + 2);
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    parameter int DW   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic [PINS-1:0]   pin_i,
    input  logic [PINS-1:0]   alt_out_i,
    input  logic [PINS-1:0]   alt_oe_i,
    output logic [PINS-1:0]   pin_o,
    output logic [PINS-1:0]   pin_oe_o,
    output logic [PINS-1:0]   pull_en_o,
    output logic [PINS-1:0]   pull_up_o,
    output logic              irq_o
);
    localparam int SYNC_STAGES = 2;

    reg_addr_e       addr;
    logic            wr_en, rd_en, vec_rd;
    logic [PINS-1:0] dout_q, dir_q, asel_q, pull_q, pol_q, ien_q;
    logic [PINS-1:0] pins_s, sense, set, flag, pend, hit, clr_mask;
    logic [DW-1:0]   vec;

    assign addr   = reg_addr_e'(bus_addr_i);
    assign wr_en  = bus_sel_i & bus_wr_i;
    assign rd_en  = bus_sel_i & ~bus_wr_i;
    assign vec_rd = rd_en && (addr == REG_VEC);

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pin_i),
        .q_o   (pins_s)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dout_q <= '0;
            dir_q  <= '0;
            asel_q <= '0;
            pull_q <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                REG_DOUT: dout_q <= bus_wdata_i[PINS-1:0];
                REG_DIR:  dir_q  <= bus_wdata_i[PINS-1:0];
                REG_ASEL: asel_q <= bus_wdata_i[PINS-1:0];
                REG_PULL: pull_q <= bus_wdata_i[PINS-1:0];
                REG_POL:  pol_q  <= bus_wdata_i[PINS-1:0];
                REG_IEN:  ien_q  <= bus_wdata_i[PINS-1:0];
                default:  ;
            endcase
        end
    end

    assign sense    = pol_q ^ pins_s;
    assign clr_mask = vec_rd ? hit : '0;

    gpio_flag_bank #(.W(PINS)) flags_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sense_i   (sense),
        .sw_we_i   (wr_en && (addr == REG_FLAG)),
        .sw_data_i (bus_wdata_i[PINS-1:0]),
        .clr_mask_i(clr_mask),
        .set_o     (set),
        .flag_o    (flag)
    );

    assign pend = flag & ien_q;

    gpio_prio_vec #(.W(PINS), .DW(DW)) prio_i (
        .pend_i(pend),
        .hit_o (hit),
        .vec_o (vec)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (addr)
            REG_PINS: bus_rdata_o[PINS-1:0] = pins_s;
            REG_DOUT: bus_rdata_o[PINS-1:0] = dout_q;
            REG_DIR:  bus_rdata_o[PINS-1:0] = dir_q;
            REG_ASEL: bus_rdata_o[PINS-1:0] = asel_q;
            REG_PULL: bus_rdata_o[PINS-1:0] = pull_q;
            REG_POL:  bus_rdata_o[PINS-1:0] = pol_q;
            REG_IEN:  bus_rdata_o[PINS-1:0] = ien_q;
            REG_FLAG: bus_rdata_o[PINS-1:0] = flag;
            REG_VEC:  bus_rdata_o           = vec;
            default:  bus_rdata_o           = '0;
        endcase
    end

    assign pin_o     = (asel_q & alt_out_i) | (~asel_q & dout_q);
    assign pin_oe_o  = (asel_q & alt_oe_i)  | (~asel_q & dir_q);
    assign pull_en_o = pull_q;
    assign pull_up_o = dout_q;
    assign irq_o     = |pend;

    // R9: a nonzero vector names a pending pin with no lower pending pin
    a_r9_vec_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec != '0) |-> (((pend & hit) != '0) && ((pend & (hit - 1'b1)) == '0)));

    // R10: the reported flag is gone after the vector read unless re-set
    a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_rd && vec != '0) |=> ((flag & $past(hit & ~set)) == '0));

    // R3: a direction write reaches the enables of GPIO-owned pins
    a_r3_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en && addr == REG_DIR && !(wr_en && addr == REG_ASEL))
        |=> ((pin_oe_o & ~asel_q) == ($past(bus_wdata_i[PINS-1:0]) & ~asel_q)));

    // R7: no request without a pending flag
    a_r7_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (vec != '0));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic [7:0]  pins = '0, alt_out = '0, alt_oe = '0;
    logic [7:0]  pin_o, pin_oe, pull_en, pull_up;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    gpio_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_i(pins), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
        .pin_o(pin_o), .pin_oe_o(pin_oe), .pull_en_o(pull_en),
        .pull_up_o(pull_up), .irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0;
        #1;
    endtask

    // table: {enable, flags written, expected vector}
    localparam logic [23:0] VTAB [6] = '{
        {8'hFF, 8'h00, 8'd0},
        {8'hFF, 8'h01, 8'd2},
        {8'hFF, 8'h80, 8'd16},
        {8'hF0, 8'h0F, 8'd0},
        {8'hF0, 8'h3C, 8'd10},
        {8'h0A, 8'hFF, 8'd4}
    };

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  fexp;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;

        // R1 reset state
        check("R1 oe", {8'h0, pin_oe}, 16'h0);
        check("R1 pull", {8'h0, pull_en}, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);
        for (int a = 1; a <= 8; a++) begin
            bus_read(a[3:0], d);
            check("R1 reg", d, 16'h0);
        end

        // R9 R10 vector table
        foreach (VTAB[i]) begin
            bus_write(4'd7, {8'h0, VTAB[i][15:8]});
            bus_write(4'd6, {8'h0, VTAB[i][23:16]});
            bus_read(4'd8, d);
            check("R9 vector", d, {8'h0, VTAB[i][7:0]});
            fexp = VTAB[i][15:8];
            if (VTAB[i][7:0] != 0) fexp[(VTAB[i][7:0] - 2) / 2] = 1'b0;
            bus_read(4'd7, d);
            check("R10 flags after vector read", d, {8'h0, fexp});
            check("R7 irq", {15'h0, irq}, {15'h0, |(fexp & VTAB[i][23:16])});
        end

        // R3 GPIO drive
        bus_write(4'd7, 16'h0);
        bus_write(4'd1, 16'h00A5);
        bus_write(4'd2, 16'h000F);
        check("R3 pin_o", {8'h0, pin_o}, 16'h00A5);
        check("R3 pin_oe", {8'h0, pin_oe}, 16'h000F);

        // R4 alternate select
        alt_out = 8'h3C; alt_oe = 8'hFF;
        bus_write(4'd3, 16'h00F0);
        check("R4 pin_o", {8'h0, pin_o}, 16'h0035);
        check("R4 pin_oe", {8'h0, pin_oe}, 16'h00FF);
        bus_write(4'd1, 16'h005A);
        check("R4 gpio ignored on alt pins", {8'h0, pin_o}, 16'h003A);
        bus_write(4'd1, 16'h00A5);

        // R5 pulls
        bus_write(4'd4, 16'h00C3);
        check("R5 pull_en", {8'h0, pull_en}, 16'h00C3);
        check("R5 pull_up", {8'h0, pull_up}, 16'h00A5);

        // R2 synchroniser latency
        @(negedge clk) pins = 8'h5A;
        addr = 4'd0;
        @(posedge clk); @(negedge clk); #1;
        check("R2 not after one edge", rdata, 16'h0000);
        @(posedge clk); @(negedge clk); #1;
        check("R2 after two edges", rdata, 16'h005A);

        // R6 rising edge with polarity 0
        bus_write(4'd7, 16'h0);
        bus_write(4'd6, 16'h00FF);
        @(negedge clk) pins = 8'h5B;
        addr = 4'd7;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check("R6 flag not yet", rdata, 16'h0000);
        @(posedge clk); @(negedge clk); #1;
        check("R6 rising flag", rdata, 16'h0001);
        check("R7 irq on flag", {15'h0, irq}, 16'h1);

        // R6 falling edge with polarity 1
        bus_write(4'd5, 16'h0002);
        bus_write(4'd7, 16'h0);
        check("R7 irq cleared", {15'h0, irq}, 16'h0);
        @(negedge clk) pins = 8'h59;
        repeat (4) @(posedge clk);
        bus_read(4'd7, d);
        check("R6 falling flag", d, 16'h0002);
        bus_write(4'd7, 16'h0);
        @(negedge clk) pins = 8'h5B;
        repeat (4) @(posedge clk);
        bus_read(4'd7, d);
        check("R6 opposite edge ignored", d, 16'h0000);

        // R8 hardware set beats same-cycle clear
        @(negedge clk) pins = 8'h5F;
        repeat (2) @(posedge clk);
        bus_write(4'd7, 16'h0);
        bus_read(4'd7, d);
        check("R8 hw set wins", d, 16'h0004);

        // R8 software set
        bus_write(4'd7, 16'h0040);
        bus_write(4'd6, 16'h0040);
        check("R8 sw set irq", {15'h0, irq}, 16'h1);
        bus_read(4'd8, d);
        check("R9 sw-set vector", d, 16'd14);
        check("R10 irq after retire", {15'h0, irq}, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule